// File: doc/BRIEF.md
# Hashed Exact-Match Address Table

This block is an exact-match table for layer-2 forwarding. A 48-bit station address is hashed with a CRC-16 function. The low bits of that CRC pick a bucket, and each bucket holds a fixed number of slots. Each slot stores a key, a data word and an occupancy bit, and all slots sit in one synchronous memory that returns a read one cycle after the address is given.

A request carries an operation code, a key and a data word. Three operations exist: find, add and remove. The controller reads the slots of the selected bucket one per clock, starting at slot 0. For a find or a remove it stops at the first occupied slot whose key matches. An add that finds no match scans the whole bucket and then writes the lowest empty slot it saw. Because of this, the time to answer depends on where the key sits in its bucket.

Each response reports a hit flag, a data word, the slot address (bucket times slots-per-bucket plus slot) and an overflow flag. The response stays valid until the consumer accepts it. A new request is taken only when the controller is idle.

Top module: `mac_lookup_table`

## Requirements
- R1: The bucket of a key is the low IDX_W bits of a CRC-16 over its 48 bits. The CRC uses polynomial 0x8005 (x^16+x^15+x^2+1), starts from zero, feeds the most significant key bit first, and has no reflection and no final XOR. A slot address is bucket*SLOTS + slot.
- R2: Operation code 0 is find, 1 is add, 2 is remove and 3 also acts as find. A find of a stored key returns hit=1, the stored data and that entry's slot address.
- R3: A find, add or remove that matches no occupied slot returns hit=0 and data 0. For find and remove the address is also 0.
- R4: Counted from the accepting clock edge, the response becomes valid s+1 cycles later when the key matches at slot s. It becomes valid SLOTS cycles later when no slot matches.
- R5: An add of a key that is not present writes the lowest-numbered empty slot of its bucket. It returns hit=0, overflow=0 and that slot's address.
- R6: An add of a key that is already present replaces its data in place. It returns hit=1, the previous data and the existing address, and uses no further slot.
- R7: An add to a bucket with no empty slot and no match returns overflow=1, hit=0, data 0 and address 0, and leaves the table unchanged.
- R8: A remove of a present key returns hit=1, the removed data and its address, and frees that slot. Later finds of the key miss, later scans continue past the freed slot, and the next add to that bucket reuses it.
- R9: req_ready is high only while idle and never while rsp_valid is high. A response held with rsp_ready low keeps all of its fields unchanged.
- R10: After reset the table is empty, req_ready is 1 and rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_op | input | 2 | 0 find, 1 add, 2 remove, 3 find |
| req_key | input | KEY_W (48) | Station address to search |
| req_data | input | DATA_W (16) | Data for an add |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Key was found |
| rsp_ovf | output | 1 | Add failed on a full bucket |
| rsp_data | output | DATA_W (16) | Stored data on a hit, else 0 |
| rsp_addr | output | IDX_W+SLOT_W (6) | Slot address of the entry |

## Verification
The bench fills one bucket with colliding keys and then times finds at every slot position. A controller that does not stop at the first match, or that miscounts probes, shows a wrong latency. A fifth add to the full bucket must report overflow and must not clobber a slot. A second add of a present key must overwrite in place and not take a second slot. After a remove in the middle of the bucket, a find of a key stored further along must still reach it, and a following add must land in the hole rather than in a later empty slot. Responses are held with backpressure so that any field that changes while waiting is caught.

// File: rtl/mlt_pkg.sv
package mlt_pkg;

    typedef enum logic [1:0] {
        OP_FIND  = 2'd0,
        OP_ADD   = 2'd1,
        OP_DEL   = 2'd2,
        OP_FIND2 = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROBE = 2'd1,
        ST_RESP  = 2'd2
    } fsm_e;

    localparam logic [15:0] CRC_POLY = 16'h8005;

endpackage

// File: rtl/mlt_hash.sv
module mlt_hash #(
    parameter int KEY_W = 48,
    parameter int IDX_W = 4
) (
    input  logic [KEY_W-1:0] key,
    output logic [IDX_W-1:0] idx
);
    import mlt_pkg::*;

    function automatic logic [IDX_W-1:0] fold_crc(input logic [KEY_W-1:0] k);
        logic [15:0] c;
        logic        fb;
        c = '0;
        for (int i = KEY_W - 1; i >= 0; i--) begin
            fb = c[15] ^ k[i];
            c  = {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
        end
        return c[IDX_W-1:0];
    endfunction

    always_comb begin
        idx = fold_crc(key);
    end

endmodule

// File: rtl/mlt_mem.sv
module mlt_mem #(
    parameter int KEY_W  = 48,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_vld,
    output logic [KEY_W-1:0]  rd_key,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_vld,
    input  logic [KEY_W-1:0]  wr_key,
    input  logic [DATA_W-1:0] wr_data
);
    logic [KEY_W-1:0]  key_mem  [DEPTH];
    logic [DATA_W-1:0] data_mem [DEPTH];
    logic [DEPTH-1:0]  occ_d, occ_q;
    logic              rvld_d, rvld_q;
    logic [KEY_W-1:0]  rkey_q;
    logic [DATA_W-1:0] rdat_q;

    always_comb begin
        occ_d  = occ_q;
        rvld_d = rvld_q;
        if (wr_en) occ_d[wr_addr] = wr_vld;
        if (rd_en) rvld_d = occ_q[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q  <= '0;
            rvld_q <= 1'b0;
        end else begin
            occ_q  <= occ_d;
            rvld_q <= rvld_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            key_mem[wr_addr]  <= wr_key;
            data_mem[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rkey_q <= key_mem[rd_addr];
            rdat_q <= data_mem[rd_addr];
        end
    end

    assign rd_vld  = rvld_q;
    assign rd_key  = rkey_q;
    assign rd_data = rdat_q;

    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en)); // R4

endmodule

// File: rtl/mlt_ctrl.sv
module mlt_ctrl #(
    parameter int KEY_W  = 48,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4,
    parameter int SLOTS  = 4,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int ADDR_W = IDX_W + SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [KEY_W-1:0]  req_key,
    input  logic [DATA_W-1:0] req_data,
    input  logic [IDX_W-1:0]  hash_idx,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              mem_vld,
    input  logic [KEY_W-1:0]  mem_key,
    input  logic [DATA_W-1:0] mem_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_vld,
    output logic [KEY_W-1:0]  wr_key,
    output logic [DATA_W-1:0] wr_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_hit,
    output logic              rsp_ovf,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] rsp_addr
);
    import mlt_pkg::*;

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    typedef struct packed {
        fsm_e              fsm;
        op_e               op;
        logic [KEY_W-1:0]  key;
        logic [DATA_W-1:0] data;
        logic [IDX_W-1:0]  bucket;
        logic [SLOT_W-1:0] slot;
        logic              free_found;
        logic [SLOT_W-1:0] free_slot;
        logic              hit;
        logic              ovf;
        logic [DATA_W-1:0] rdata;
        logic [ADDR_W-1:0] raddr;
    } state_t;

    state_t            st_d, st_q;
    logic              match;
    logic              free_here;
    logic              pick_ok;
    logic [SLOT_W-1:0] pick_slot;
    logic [SLOT_W-1:0] slot_nx;
    logic              is_add, is_del;

    always_comb begin
        st_d      = st_q;
        rd_en     = 1'b0;
        rd_addr   = {st_q.bucket, st_q.slot};
        wr_en     = 1'b0;
        wr_addr   = {st_q.bucket, st_q.slot};
        wr_vld    = 1'b1;
        wr_key    = st_q.key;
        wr_data   = st_q.data;
        match     = mem_vld && (mem_key == st_q.key);
        free_here = !mem_vld;
        pick_ok   = st_q.free_found || free_here;
        pick_slot = st_q.free_found ? st_q.free_slot : st_q.slot;
        slot_nx   = st_q.slot + 1'b1;
        is_add    = (st_q.op == OP_ADD);
        is_del    = (st_q.op == OP_DEL);

        case (st_q.fsm)
            ST_IDLE: begin
                if (req_valid) begin
                    st_d.fsm        = ST_PROBE;
                    st_d.op         = op_e'(req_op);
                    st_d.key        = req_key;
                    st_d.data       = req_data;
                    st_d.bucket     = hash_idx;
                    st_d.slot       = '0;
                    st_d.free_found = 1'b0;
                    st_d.free_slot  = '0;
                    rd_en           = 1'b1;
                    rd_addr         = {hash_idx, {SLOT_W{1'b0}}};
                end
            end
            ST_PROBE: begin
                if (free_here && !st_q.free_found) begin
                    st_d.free_found = 1'b1;
                    st_d.free_slot  = st_q.slot;
                end
                if (match) begin
                    st_d.fsm   = ST_RESP;
                    st_d.hit   = 1'b1;
                    st_d.ovf   = 1'b0;
                    st_d.rdata = mem_data;
                    st_d.raddr = {st_q.bucket, st_q.slot};
                    if (is_add) begin
                        wr_en = 1'b1;
                    end else if (is_del) begin
                        wr_en   = 1'b1;
                        wr_vld  = 1'b0;
                        wr_data = mem_data;
                    end
                end else if (st_q.slot == LAST_SLOT) begin
                    st_d.fsm   = ST_RESP;
                    st_d.hit   = 1'b0;
                    st_d.ovf   = 1'b0;
                    st_d.rdata = '0;
                    st_d.raddr = '0;
                    if (is_add) begin
                        if (pick_ok) begin
                            wr_en      = 1'b1;
                            wr_addr    = {st_q.bucket, pick_slot};
                            st_d.raddr = {st_q.bucket, pick_slot};
                        end else begin
                            st_d.ovf = 1'b1;
                        end
                    end
                end else begin
                    st_d.slot = slot_nx;
                    rd_en     = 1'b1;
                    rd_addr   = {st_q.bucket, slot_nx};
                end
            end
            ST_RESP: begin
                if (rsp_ready) st_d.fsm = ST_IDLE;
            end
            default: st_d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.fsm <= ST_IDLE;
            st_q.op  <= OP_FIND;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = (st_q.fsm == ST_IDLE);
    assign rsp_valid = (st_q.fsm == ST_RESP);
    assign rsp_hit   = st_q.hit;
    assign rsp_ovf   = st_q.ovf;
    assign rsp_data  = st_q.rdata;
    assign rsp_addr  = st_q.raddr;

    AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid); // R9
    AST_RSP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> $stable(rsp_hit) && $stable(rsp_ovf)
                                    && $stable(rsp_data) && $stable(rsp_addr)); // R9
    AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && rsp_valid)); // R9
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_hit |-> rsp_data == '0); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ovf |-> !rsp_hit && rsp_addr == '0); // R7
    AST_WRITE_IN_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rsp_valid); // R5

endmodule

// File: rtl/mac_lookup_table.sv
module mac_lookup_table #(
    parameter int KEY_W  = 48,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4,
    parameter int SLOTS  = 4,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int ADDR_W = IDX_W + SLOT_W,
    localparam int DEPTH  = SLOTS << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [KEY_W-1:0]  req_key,
    input  logic [DATA_W-1:0] req_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_hit,
    output logic              rsp_ovf,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] rsp_addr
);
    logic [IDX_W-1:0]  hash_idx;
    logic              rd_en, wr_en, wr_vld, mem_vld;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [KEY_W-1:0]  mem_key, wr_key;
    logic [DATA_W-1:0] mem_data, wr_data;

    mlt_hash #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_hash (
        .key (req_key),
        .idx (hash_idx)
    );

    mlt_mem #(.KEY_W(KEY_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_vld  (mem_vld),
        .rd_key  (mem_key),
        .rd_data (mem_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_vld  (wr_vld),
        .wr_key  (wr_key),
        .wr_data (wr_data)
    );

    mlt_ctrl #(.KEY_W(KEY_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .SLOTS(SLOTS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_key   (req_key),
        .req_data  (req_data),
        .hash_idx  (hash_idx),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .mem_vld   (mem_vld),
        .mem_key   (mem_key),
        .mem_data  (mem_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_vld    (wr_vld),
        .wr_key    (wr_key),
        .wr_data   (wr_data),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_hit   (rsp_hit),
        .rsp_ovf   (rsp_ovf),
        .rsp_data  (rsp_data),
        .rsp_addr  (rsp_addr)
    );

endmodule

// File: tb/tb_mac_lookup_table.sv
`timescale 1ns/1ps
module tb_mac_lookup_table;
    localparam int KW = 48, DW = 16, IW = 4, NS = 4, SW = 2, AW = 6, NE = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, rsp_ready = 1'b0;
    logic [1:0]    req_op = '0;
    logic [KW-1:0] req_key = '0;
    logic [DW-1:0] req_data = '0;
    logic          req_ready, rsp_valid, rsp_hit, rsp_ovf;
    logic [DW-1:0] rsp_data;
    logic [AW-1:0] rsp_addr;

    always #5 clk = ~clk;

    mac_lookup_table dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_key(req_key), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
        .rsp_ovf(rsp_ovf), .rsp_data(rsp_data), .rsp_addr(rsp_addr)
    );

    int checks = 0, fails = 0, cyc = 0, issued = 0, done_cnt = 0;
    bit ended = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        bit hit; bit ovf; logic [DW-1:0] data; logic [AW-1:0] addr;
        int lat; int acc; string tag;
    } exp_t;
    exp_t sb[$];

    bit            m_vld [NE];
    logic [KW-1:0] m_key [NE];
    logic [DW-1:0] m_dat [NE];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int bucket_of(input logic [KW-1:0] k);
        logic [15:0] c = 16'h0;
        logic fb;
        for (int i = KW - 1; i >= 0; i--) begin
            fb = c[15] ^ k[i];
            c  = {c[14] ^ fb, c[13:2], c[1] ^ fb, c[0], fb};
        end
        return int'(c[IW-1:0]);
    endfunction

    task automatic run_op(input int op, input logic [KW-1:0] k, input logic [DW-1:0] d, input string tag);
        exp_t e;
        int b = bucket_of(k), ms = -1, ff = -1;
        for (int s = 0; s < NS; s++) begin
            if (m_vld[b*NS+s] && m_key[b*NS+s] == k && ms < 0) ms = s;
            if (!m_vld[b*NS+s] && ff < 0) ff = s;
        end
        e.tag = tag; e.hit = 0; e.ovf = 0; e.data = '0; e.addr = '0; e.lat = NS;
        if (ms >= 0) begin
            e.hit = 1; e.data = m_dat[b*NS+ms]; e.addr = AW'(b*NS+ms); e.lat = ms + 1;
            if (op == 1) m_dat[b*NS+ms] = d;
            if (op == 2) m_vld[b*NS+ms] = 0;
        end else if (op == 1) begin
            if (ff >= 0) begin
                e.addr = AW'(b*NS+ff);
                m_vld[b*NS+ff] = 1; m_key[b*NS+ff] = k; m_dat[b*NS+ff] = d;
            end else e.ovf = 1;
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_op = 2'(op); req_key = k; req_data = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        e.acc = cyc;
        sb.push_back(e);
        issued++;
        wait (done_cnt == issued);
    endtask

    // monitor: pops the scoreboard on each response and holds it with backpressure
    initial begin
        exp_t e;
        int lat, hold;
        logic [DW-1:0] d0; logic [AW-1:0] a0; logic h0, o0;
        forever begin
            @(negedge clk);
            if (rsp_valid) begin
                lat = cyc;
                if (sb.size() == 0) begin
                    chk(0, "R9 unexpected response", 1, 0);
                end else begin
                    e = sb.pop_front();
                    lat = lat - e.acc;
                    chk(rsp_hit == e.hit, {e.tag, " hit"}, rsp_hit, e.hit);
                    chk(rsp_data == e.data, {e.tag, " data"}, rsp_data, e.data);
                    chk(rsp_addr == e.addr, {e.tag, " addr"}, rsp_addr, e.addr);
                    chk(rsp_ovf == e.ovf, {e.tag, " ovf"}, rsp_ovf, e.ovf);
                    chk(lat == e.lat, {e.tag, " R4 latency"}, lat, e.lat);
                end
                h0 = rsp_hit; o0 = rsp_ovf; d0 = rsp_data; a0 = rsp_addr;
                hold = done_cnt % 3;
                for (int i = 0; i < hold; i++) begin
                    @(negedge clk);
                    chk(rsp_valid && rsp_hit == h0 && rsp_ovf == o0 && rsp_data == d0
                        && rsp_addr == a0, "R9 held response", {rsp_data, rsp_addr}, {d0, a0});
                    chk(!req_ready, "R9 ready while responding", req_ready, 0);
                end
                rsp_ready = 1;
                @(negedge clk);
                rsp_ready = 0;
                chk(!rsp_valid, "R9 response consumed", rsp_valid, 0);
                done_cnt++;
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    logic [KW-1:0] ck [5];
    logic [KW-1:0] ok [3];

    initial begin
        int n = 0, m = 0, b0;
        logic [KW-1:0] cand;
        for (int i = 0; i < NE; i++) m_vld[i] = 0;
        b0 = bucket_of(48'hA0B1_C2D3_0000);
        for (int i = 0; i < 4000 && (n < 5 || m < 3); i++) begin
            cand = 48'hA0B1_C2D3_0000 + KW'(i);
            if (bucket_of(cand) == b0 && n < 5) begin ck[n] = cand; n++; end
            else if (bucket_of(cand) != b0 && m < 3) begin ok[m] = cand; m++; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1, "R10 ready after reset", req_ready, 1);
        chk(rsp_valid == 0, "R10 no response after reset", rsp_valid, 0);

        run_op(0, ck[0], '0, "R10 find on empty table");
        run_op(1, ck[0], 16'h1111, "R1/R5 add slot0");
        run_op(1, ck[1], 16'h2222, "R5 add slot1");
        run_op(1, ck[2], 16'h3333, "R5 add slot2");
        run_op(1, ck[3], 16'h4444, "R5 add slot3");
        run_op(1, ck[4], 16'h5555, "R7 add to full bucket");
        run_op(0, ck[0], '0, "R2 find slot0");
        run_op(0, ck[1], '0, "R2 find slot1");
        run_op(3, ck[2], '0, "R2 code3 find slot2");
        run_op(0, ck[3], '0, "R2 find slot3");
        run_op(0, ck[4], '0, "R7 rejected key absent");
        run_op(1, ck[2], 16'hABCD, "R6 overwrite existing");
        run_op(0, ck[2], '0, "R6 find overwritten");
        run_op(2, ck[1], '0, "R8 remove slot1");
        run_op(0, ck[1], '0, "R3 find removed");
        run_op(2, ck[1], '0, "R3 remove absent");
        run_op(0, ck[3], '0, "R8 scan past hole");
        run_op(1, ck[4], 16'h5A5A, "R8 add reuses hole");
        run_op(0, ck[4], '0, "R8 find in reused slot");
        run_op(1, ok[0], 16'h0F0F, "R1 add other bucket");
        run_op(1, ok[1], 16'hF00F, "R1 add other bucket");
        run_op(0, ok[0], '0, "R1 find other bucket");
        run_op(0, ok[2], '0, "R3 find never added");
        run_op(2, ok[1], '0, "R8 remove other bucket");
        run_op(0, ok[1], '0, "R8 find after remove");
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule